// File: doc/BRIEF.md
# Streaming Fixed-Point Multiply-Accumulate Engine

This block computes `r_i = s * x_i + y_i` element by element over two vectors that arrive as 64-bit AXI4-Stream flows, and sends the results out on a third 64-bit AXI4-Stream flow. Every value is signed Q32.32 fixed point. The scalar `s` and a precision word are written through a small register port once per vector. They then stay fixed while the elements stream through a pipeline of fixed depth that accepts one element pair on every clock.

For round-off studies, each of five points in the datapath can receive a pseudo-random perturbation of its low bits. The five points are the scalar, the x operand, the rounded product, the y operand and the sum. The precision word sets how many low bits are disturbed. A value of zero gives exact, repeatable arithmetic. A done flag reports that the element closing a vector has left the engine.

Top module: `vmac_stream`

## Requirements
- R1: Register port, word addressed. 0 holds the scalar's low 32 bits and 1 its high 32 bits. 2 holds the precision word. 3 is control/status: a write with bit 0 set clears done, and a read returns done in bit 0. 4 sets the perturbation seed. Addresses 0, 1 and 2 read back what was written. After reset every register reads 0 and `m_tvalid` is 0.
- R2: An element pair is consumed only in a cycle where both `x_tvalid` and `y_tvalid` are high and the pipeline can advance. `x_tready` and `y_tready` are then high together. With only one input valid, neither ready is raised and nothing is consumed.
- R3: With precision word 0, the result is `sat(sat(round(s*x)) + y)`. `round` takes the 128-bit product back to Q32.32 by rounding to nearest, with ties away from zero.
- R4: Any product or sum outside the signed 64-bit range saturates to 0x7FFF_FFFF_FFFF_FFFF or to 0x8000_0000_0000_0000.
- R5: There are 21 register stages. A pair accepted at one clock edge first shows `m_tvalid` high after the 20th following edge.
- R6: With the output ready held high, one pair is accepted per clock, and results leave in input order with none lost or repeated.
- R7: While `m_tvalid` is high and `m_tready` is low, the whole pipeline holds. The output data and last flag stay stable, and both input readies stay low.
- R8: `m_tlast` is high on the result of the pair whose `x_tlast` was high. Done sets after that result is transferred.
- R9: With precision word k (1 to 32), each of the five points has its low k bits XORed with bits from a 32-bit maximal-length LFSR. The result therefore stays within a small bound of the exact value, and it differs from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| x_tdata | input | 64 | X element, Q32.32 |
| x_tvalid | input | 1 | X valid |
| x_tlast | input | 1 | Marks the last X element of a vector |
| x_tready | output | 1 | X accepted |
| y_tdata | input | 64 | Y element, Q32.32 |
| y_tvalid | input | 1 | Y valid |
| y_tready | output | 1 | Y accepted |
| m_tdata | output | 64 | Result element, Q32.32 |
| m_tvalid | output | 1 | Result valid |
| m_tlast | output | 1 | Result closes the vector |
| m_tready | input | 1 | Downstream ready |

## Verification
The assertions check the stream handshake rules on every cycle. These are the lockstep readies of the inputs, the freeze of the output and of both readies during a stall, and the rule that done rises only after a last result is transferred. Only the bench's scenarios can show the numeric behaviour: the rounding ties in both signs, saturation in the product and in the sum, the exact 21-stage latency, the ordering under an irregular output-ready pattern, and the bounded effect of perturbation.

// File: rtl/vmac_stream.sv
module vmac_stream #(
  parameter int DW   = 64,
  parameter int FRAC = 32,
  parameter int LAT  = 21,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [DW-1:0] x_tdata,
  input  logic          x_tvalid,
  input  logic          x_tlast,
  output logic          x_tready,
  input  logic [DW-1:0] y_tdata,
  input  logic          y_tvalid,
  output logic          y_tready,
  output logic [DW-1:0] m_tdata,
  output logic          m_tvalid,
  output logic          m_tlast,
  input  logic          m_tready
);
  localparam int PW = 2 * DW;
  localparam int NSITE = 5;
  localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [PW:0] HALF = (PW+1)'(1) <<< (FRAC-1);

  logic [DW-1:0] scale;
  logic [31:0]   prec, lfsr;
  logic          done;
  logic [LAT:1]  vld, lst;
  logic [DW-1:0] s1_a, s1_x, s1_y, s2_y, s3_p, s3_y;
  logic signed [PW-1:0] s2_p;
  logic [DW-1:0] dly [4:LAT];
  logic [31:0]   rnd [NSITE];
  logic [5:0]    kcap;
  logic [DW-1:0] mask;
  logic          adv, take;

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [DW-1:0] sat(input logic signed [PW:0] v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v[DW-1:0];
  endfunction

  always_comb begin
    rnd[0] = lfsr_step(lfsr);
    for (int i = 1; i < NSITE; i++) rnd[i] = lfsr_step(rnd[i-1]);
  end

  assign kcap = (prec[5:0] > 6'd32) ? 6'd32 : prec[5:0];
  assign mask = (DW'(1) << kcap) - DW'(1);

  function automatic logic [DW-1:0] pert(input logic [DW-1:0] v, input logic [31:0] r);
    return v ^ ({{(DW-32){1'b0}}, r} & mask);
  endfunction

  assign adv      = !m_tvalid || m_tready;
  assign take     = adv && x_tvalid && y_tvalid;
  assign x_tready = take;
  assign y_tready = take;
  assign m_tvalid = vld[LAT];
  assign m_tlast  = lst[LAT];
  assign m_tdata  = dly[LAT];

  logic signed [PW-1:0] prod_w;
  logic signed [PW:0]   rsum, rshift, ssum;
  assign prod_w = $signed({{DW{s1_a[DW-1]}}, s1_a}) * $signed({{DW{s1_x[DW-1]}}, s1_x});
  assign rsum   = {s2_p[PW-1], s2_p} + (s2_p[PW-1] ? HALF - 1 : HALF);
  assign rshift = rsum >>> FRAC;
  assign ssum   = $signed({{(DW+1){s3_p[DW-1]}}, s3_p}) + $signed({{(DW+1){s3_y[DW-1]}}, s3_y});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale <= '0;
      prec  <= '0;
      lfsr  <= 32'h1;
      done  <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          AW'(0): scale[31:0]    <= cfg_wdata;
          AW'(1): scale[DW-1:32] <= cfg_wdata[DW-33:0];
          AW'(2): prec           <= cfg_wdata;
          default: ;
        endcase
      end
      if (cfg_we && cfg_addr == AW'(4)) lfsr <= (cfg_wdata == '0) ? 32'h1 : cfg_wdata;
      else if (adv) lfsr <= rnd[NSITE-1];
      if (m_tvalid && m_tready && m_tlast) done <= 1'b1;
      else if (cfg_we && cfg_addr == AW'(3) && cfg_wdata[0]) done <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      lst <= '0;
    end else if (adv) begin
      vld <= {vld[LAT-1:1], take};
      lst <= {lst[LAT-1:1], take && x_tlast};
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_a <= pert(scale, rnd[0]);
      s1_x <= pert(x_tdata, rnd[1]);
      s1_y <= pert(y_tdata, rnd[2]);
      s2_p <= prod_w;
      s2_y <= s1_y;
      s3_p <= pert(sat(rshift), rnd[3]);
      s3_y <= s2_y;
      dly[4] <= pert(sat(ssum), rnd[4]);
      for (int i = LAT; i > 4; i--) dly[i] <= dly[i-1];
    end
  end

  always_comb begin
    case (cfg_addr)
      AW'(0):  cfg_rdata = scale[31:0];
      AW'(1):  cfg_rdata = scale[DW-1:32];
      AW'(2):  cfg_rdata = prec;
      AW'(3):  cfg_rdata = {31'b0, done};
      default: cfg_rdata = '0;
    endcase
  end
endmodule

module vmac_stream_chk (
  input logic clk,
  input logic rst_n,
  input logic x_tvalid,
  input logic y_tvalid,
  input logic x_tready,
  input logic y_tready,
  input logic [63:0] m_tdata,
  input logic m_tvalid,
  input logic m_tlast,
  input logic m_tready,
  input logic done
);
  assert_lockstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (x_tready || y_tready) |-> (x_tready && y_tready && x_tvalid && y_tvalid));

  assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  assert_stall_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |-> (!x_tready && !y_tready));

  assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(m_tvalid && m_tready && m_tlast));
endmodule

bind vmac_stream vmac_stream_chk u_chk (
  .clk(clk), .rst_n(rst_n), .x_tvalid(x_tvalid), .y_tvalid(y_tvalid),
  .x_tready(x_tready), .y_tready(y_tready), .m_tdata(m_tdata),
  .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready), .done(done)
);

// File: tb/vmac_stream_tb.sv
module vmac_stream_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [63:0] x_tdata = 0, y_tdata = 0, m_tdata;
  logic x_tvalid = 0, x_tlast = 0, y_tvalid = 0, m_tready = 1;
  logic x_tready, y_tready, m_tvalid, m_tlast;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  vmac_stream u_dut (.*);

  localparam int NV = 10;
  localparam logic [63:0] TA [NV] = '{
    64'h0000_0002_0000_0000, 64'h0000_0002_0000_0000, 64'h0000_0000_8000_0000,
    64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 64'h4000_0000_0000_0000,
    64'h4000_0000_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000,
    64'hFFFF_FFFF_0000_0000};
  localparam logic [63:0] TX [NV] = '{
    64'h0000_0001_8000_0000, 64'hFFFF_FFFE_8000_0000, 64'h3,
    64'hFFFF_FFFF_FFFF_FFFD, 64'h1, 64'h4000_0000_0000_0000,
    64'hC000_0000_0000_0000, 64'h7000_0000_0000_0000, 64'h9000_0000_0000_0000,
    64'h0000_0005_0000_0000};
  localparam logic [63:0] TY [NV] = '{
    64'h0000_0000_4000_0000, 64'h0, 64'h0, 64'h0, 64'hA, 64'h0, 64'h0,
    64'h7000_0000_0000_0000, 64'h9000_0000_0000_0000, 64'h0000_0005_0000_0000};
  localparam logic [63:0] TE [NV] = '{
    64'h0000_0003_4000_0000, 64'hFFFF_FFFD_0000_0000, 64'h2,
    64'hFFFF_FFFF_FFFF_FFFE, 64'hB, 64'h7FFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
    64'h0};
  localparam string TR [NV] = '{"R3", "R3", "R3", "R3", "R3", "R4", "R4", "R4", "R4", "R3"};

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic send(logic [63:0] x, logic [63:0] y, logic last);
    @(negedge clk); x_tdata = x; y_tdata = y; x_tlast = last; x_tvalid = 1; y_tvalid = 1;
    #1 while (!x_tready) begin @(negedge clk); #1; end
    @(posedge clk); #1 x_tvalid = 0; y_tvalid = 0; x_tlast = 0;
  endtask

  task automatic recv(output logic [63:0] d, output logic l);
    @(negedge clk);
    while (!m_tvalid) @(negedge clk);
    d = m_tdata; l = m_tlast;
    @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] d;
    logic l;
    int n;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, r); check("R1 scale reset", 64'(r), 0);
    rd(3, r); check("R1 done reset", 64'(r), 0);
    check("R1 m_tvalid reset", 64'(m_tvalid), 0);

    // Vector table: R3 rounding ties, R4 saturation
    for (int i = 0; i < NV; i++) begin
      wr(0, TA[i][31:0]); wr(1, TA[i][63:32]);
      send(TX[i], TY[i], 1'b1);
      recv(d, l);
      check(TR[i], d, TE[i]);
    end
    rd(0, r); check("R1 scale lo readback", 64'(r), 64'(TA[NV-1][31:0]));
    rd(1, r); check("R1 scale hi readback", 64'(r), 64'(TA[NV-1][63:32]));

    // R8 done set and cleared
    rd(3, r); check("R8 done set", 64'(r), 1);
    wr(3, 1); rd(3, r); check("R1 done clear", 64'(r), 0);

    // R5 latency
    wr(0, 0); wr(1, 1);
    fork
      send(64'h0000_0001_0000_0000, 0, 1'b0);
      begin
        @(posedge clk iff (x_tready === 1'b1));
        n = 0;
        do begin @(posedge clk); n++; #1; end while (!m_tvalid && n < 100);
      end
    join
    check("R5 latency", 64'(n), 20);
    recv(d, l);
    check("R5 value", d, 64'h0000_0001_0000_0000);
    check("R8 tlast absent", 64'(l), 0);

    // R2 lockstep: X alone is not consumed
    @(negedge clk); x_tdata = 64'h7; x_tvalid = 1; y_tvalid = 0;
    n = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk); #1;
      if (x_tready || y_tready || m_tvalid) n++;
    end
    check("R2 single valid ignored", 64'(n), 0);
    @(negedge clk); y_tdata = 64'h1; y_tvalid = 1;
    #1 while (!x_tready) begin @(negedge clk); #1; end
    @(posedge clk); #1 x_tvalid = 0; y_tvalid = 0;
    recv(d, l);
    check("R2 joined pair", d, 64'h8);

    // R6/R7 burst with irregular output ready
    fork
      for (int i = 1; i <= 30; i++) send(64'(i), 64'(2 * i), i == 30);
      begin
        int got = 0, cyc = 0, bad = 0;
        logic lastok = 0;
        while (got < 30 && cyc < 2000) begin
          @(negedge clk); m_tready = (cyc % 3) != 0; cyc++; #1;
          if (m_tvalid && m_tready) begin
            got++;
            if (m_tdata !== 64'(3 * got)) begin
              bad++;
              $display("FAIL R7 element %0d: actual %h expected %h", got, m_tdata, 64'(3 * got));
            end
            if (got == 30) lastok = m_tlast;
            else if (m_tlast) bad++;
          end
        end
        tests++; if (bad != 0) fails++;
        check("R6 burst count", 64'(got), 30);
        check("R8 burst tlast", 64'(lastok), 1);
      end
    join
    @(negedge clk); m_tready = 1;
    rd(3, r); check("R8 done after burst", 64'(r), 1);

    // R9 perturbation
    wr(4, 32'h1234_5678); wr(2, 4);
    rd(2, r); check("R1 prec readback", 64'(r), 4);
    fork
      for (int i = 0; i < 8; i++) send(64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, i == 7);
      begin
        int differ = 0, far = 0;
        for (int i = 0; i < 8; i++) begin
          logic signed [63:0] diff;
          recv(d, l);
          diff = $signed(d) - $signed(64'h0000_0002_0000_0000);
          if (diff != 0) differ++;
          if (diff > 128 || diff < -128) far++;
        end
        check("R9 bounded", 64'(far), 0);
        tests++;
        if (differ == 0) begin fails++; $display("FAIL R9 perturbed: actual 0 expected >0"); end
      end
    join
    wr(2, 0);
    wr(0, 0); wr(1, 3);
    send(64'h0000_0002_0000_0000, 64'h1, 1'b1);
    recv(d, l);
    check("R9 exact at zero", d, 64'h0000_0006_0000_0001);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule